// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

A single-clock static RAM with a registered front end and a registered read output. Every input is captured on the rising clock edge. The captured cycle is then performed against the storage array, and a read result appears on the output register one edge later. The word is 36 bits, organised as four 9-bit byte lanes. A write can touch any subset of lanes, or all of them at once through a global write.

Accesses are grouped into bursts of up to four beats. Either of two start strobes begins a burst, one meant for a processor and one for a cache controller, and the start loads the external address as the first beat. Later cycles take their address from an internal 2-bit beat counter that steps only while the advance input is high. The low two address bits follow either linear (modulo-4 increment) or interleaved (XOR) order, as chosen at burst start. Three chip enables are sampled with the strobe. If any of them is inactive, the cycle deselects the part, and the output goes quiet in the very next output cycle.

Top module: `burst_sram`

## Requirements
- R1: Pins presented before rising edge k are captured at edge k; a read's data and `rvalid_o`=1 are visible after edge k+1.
- R2: A start (`strobe_proc_i` or `strobe_ctl_i` high) with `en_hi_a_i`=1, `en_hi_b_i`=1 and `en_lo_n_i`=0 begins a burst whose first beat uses `addr_i` unchanged; either strobe has the same effect.
- R3: A start with any enable inactive is a deselect: no burst begins, the output cycle for it has `rvalid_o`=0 and `rdata_o`=0, and later cycles without a start perform no access.
- R4: In a burst, a cycle with no start and `adv_i`=1 steps the beat count by one modulo 4 (wrapping after the fourth beat); with `adv_i`=0 the current beat address is accessed again.
- R5: With `order_i`=0 sampled at the start, the beat's low two address bits are (start low bits + beat count) mod 4; the upper bits never change within a burst.
- R6: With `order_i`=1 sampled at the start, the beat's low two address bits are start low bits XOR beat count.
- R7: With `wr_global_i`=0 and `wr_byte_i`=1, lane i (bits 9i+8..9i) of the beat address takes the matching `wdata_i` lane exactly where `lane_sel_i[i]`=1; other lanes keep their value.
- R8: With `wr_global_i`=0 and `wr_byte_i`=0, the beat is a read and `lane_sel_i` and `wdata_i` change nothing.
- R9: With `wr_global_i`=1, all four lanes are written, whatever `wr_byte_i` and `lane_sel_i` are.
- R10: A write beat produces an output cycle with `rvalid_o`=0; `rdata_o` is zero whenever `rvalid_o` is 0.
- R11: While and after reset, `rvalid_o`=0, `rdata_o`=0, and no burst is in progress.
- R12: A read issued in the cycle right after a write to the same address returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Word address loaded at burst start |
| strobe_proc_i | input | 1 | Processor-side burst start strobe |
| strobe_ctl_i | input | 1 | Cache-controller-side burst start strobe |
| adv_i | input | 1 | Step the beat counter |
| en_hi_a_i | input | 1 | Chip enable, active high |
| en_hi_b_i | input | 1 | Chip enable, active high |
| en_lo_n_i | input | 1 | Chip enable, active low |
| wr_global_i | input | 1 | Write all lanes |
| wr_byte_i | input | 1 | Byte-write enable, qualifies lane_sel_i |
| lane_sel_i | input | LANES | Per-lane write select |
| wdata_i | input | LANES*LANE_W | Write data |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The array is first filled by four-beat global-write bursts, then read back by bursts from all four start offsets in both orders. These separate modulo-4 increment from XOR ordering, including the wrap after the fourth beat and the repeat of a beat when advance is low. All sixteen lane-select masks are applied once with the byte-write enable high and once with it low, which tells a real lane merge apart from an ignored mask. Back-to-back write/read pairs, each enable dropped in turn, and both start strobes separate pipeline hazards and deselect handling from ordinary reads.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    localparam int BEAT_CNT_W = 2;
    localparam int BEATS      = 1 << BEAT_CNT_W;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bsram_beat_gen.sv
module bsram_beat_gen
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]     base_i,
    input  logic [BEAT_CNT_W-1:0] cnt_i,
    input  burst_order_e          order_i,
    output logic [ADDR_W-1:0]     addr_o
);

    logic [BEAT_CNT_W-1:0] low;

    always_comb begin
        if (order_i == ORDER_XOR) begin
            low = base_i[BEAT_CNT_W-1:0] ^ cnt_i;
        end else begin
            low = base_i[BEAT_CNT_W-1:0] + cnt_i;
        end
    end

    generate
        if (ADDR_W > BEAT_CNT_W) begin : g_wide
            assign addr_o = {base_i[ADDR_W-1:BEAT_CNT_W], low};
        end else begin : g_narrow
            assign addr_o = low;
        end
    endgenerate

endmodule

// File: rtl/bsram_lane_dec.sv
module bsram_lane_dec #(
    parameter int LANES = 4
) (
    input  logic             wr_global_i,
    input  logic             wr_byte_i,
    input  logic [LANES-1:0] lane_sel_i,
    output logic [LANES-1:0] lane_we_o,
    output logic             is_write_o
);

    always_comb begin
        if (wr_global_i) begin
            lane_we_o = '1;
        end else if (wr_byte_i) begin
            lane_we_o = lane_sel_i;
        end else begin
            lane_we_o = '0;
        end
        is_write_o = |lane_we_o;
    end

endmodule

// File: rtl/bsram_core.sv
module bsram_core #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            logic [LANE_W-1:0] mem [DEPTH];

            always_ff @(posedge clk) begin
                if (lane_we_i[ln]) begin
                    mem[addr_i] <= wdata_i[ln*LANE_W +: LANE_W];
                end
            end

            assign rdata_o[ln*LANE_W +: LANE_W] = mem[addr_i];
        end
    endgenerate

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    strobe_proc_i,
    input  logic                    strobe_ctl_i,
    input  logic                    adv_i,
    input  logic                    en_hi_a_i,
    input  logic                    en_hi_b_i,
    input  logic                    en_lo_n_i,
    input  logic                    wr_global_i,
    input  logic                    wr_byte_i,
    input  logic [LANES-1:0]        lane_sel_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    order_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        // captured pins
        logic [ADDR_W-1:0]     addr;
        logic                  strobe;
        logic                  en_ok;
        logic                  adv;
        logic                  wr_glb;
        logic                  wr_byt;
        logic [LANES-1:0]      lane;
        logic [WORD_W-1:0]     wdata;
        burst_order_e          ord;
        // burst state
        logic                  act;
        logic [ADDR_W-1:0]     base;
        logic [BEAT_CNT_W-1:0] cnt;
        burst_order_e          bord;
        // output stage
        logic [WORD_W-1:0]     rdata;
        logic                  rvalid;
    } state_t;

    state_t st_d, st_q;

    logic                  start_ok, desel;
    logic                  nb_act;
    logic [ADDR_W-1:0]     nb_base;
    logic [BEAT_CNT_W-1:0] nb_cnt;
    burst_order_e          nb_ord;
    logic [ADDR_W-1:0]     beat_addr;
    logic [LANES-1:0]      dec_we, lane_we;
    logic                  dec_wr;
    logic [WORD_W-1:0]     rd_word;
    logic                  do_wr, do_rd;

    // next burst position from the captured cycle
    always_comb begin
        start_ok = st_q.strobe && st_q.en_ok;
        desel    = st_q.strobe && !st_q.en_ok;
        nb_act   = st_q.act;
        nb_base  = st_q.base;
        nb_cnt   = st_q.cnt;
        nb_ord   = st_q.bord;
        if (start_ok) begin
            nb_act  = 1'b1;
            nb_base = st_q.addr;
            nb_cnt  = '0;
            nb_ord  = st_q.ord;
        end else if (desel) begin
            nb_act  = 1'b0;
        end else if (st_q.act && st_q.adv) begin
            nb_cnt  = st_q.cnt + 1'b1;
        end
    end

    bsram_beat_gen #(.ADDR_W(ADDR_W)) beat_i (
        .base_i  (nb_base),
        .cnt_i   (nb_cnt),
        .order_i (nb_ord),
        .addr_o  (beat_addr)
    );

    bsram_lane_dec #(.LANES(LANES)) dec_i (
        .wr_global_i (st_q.wr_glb),
        .wr_byte_i   (st_q.wr_byt),
        .lane_sel_i  (st_q.lane),
        .lane_we_o   (dec_we),
        .is_write_o  (dec_wr)
    );

    assign do_wr   = nb_act && dec_wr;
    assign do_rd   = nb_act && !dec_wr;
    assign lane_we = do_wr ? dec_we : '0;

    bsram_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) core_i (
        .clk       (clk),
        .lane_we_i (lane_we),
        .addr_i    (beat_addr),
        .wdata_i   (st_q.wdata),
        .rdata_o   (rd_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.addr   = addr_i;
        st_d.strobe = strobe_proc_i || strobe_ctl_i;
        st_d.en_ok  = en_hi_a_i && en_hi_b_i && !en_lo_n_i;
        st_d.adv    = adv_i;
        st_d.wr_glb = wr_global_i;
        st_d.wr_byt = wr_byte_i;
        st_d.lane   = lane_sel_i;
        st_d.wdata  = wdata_i;
        st_d.ord    = burst_order_e'(order_i);
        st_d.act    = nb_act;
        st_d.base   = nb_base;
        st_d.cnt    = nb_cnt;
        st_d.bord   = nb_ord;
        st_d.rvalid = do_rd;
        st_d.rdata  = do_rd ? rd_word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o  = st_q.rdata;
    assign rvalid_o = st_q.rvalid;

    // views for the bound checker
    logic                  strobe_q, adv_q, act_q;
    logic [BEAT_CNT_W-1:0] cnt_q;
    assign strobe_q = st_q.strobe;
    assign adv_q    = st_q.adv;
    assign act_q    = st_q.act;
    assign cnt_q    = st_q.cnt;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_ok,
    input logic              desel,
    input logic              strobe_q,
    input logic              adv_q,
    input logic              act_q,
    input logic [1:0]        cnt_q,
    input logic              rvalid_o,
    input logic [WORD_W-1:0] rdata_o
);

    // R3
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> (!rvalid_o && rdata_o == '0));

    // R3
    idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_q && !strobe_q) |=> !rvalid_o);

    // R10
    zero_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    // R4
    adv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && adv_q && !strobe_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R4
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && !adv_q && !strobe_q) |=> $stable(cnt_q));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (act_q && cnt_q == 2'd0));

endmodule

bind burst_sram bsram_chk #(.WORD_W(WORD_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ok (start_ok),
    .desel    (desel),
    .strobe_q (strobe_q),
    .adv_q    (adv_q),
    .act_q    (act_q),
    .cnt_q    (cnt_q),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;

    localparam int AW    = 8;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int WW    = LN * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          sp = 0, sc = 0, adv = 0, ea = 0, eb = 0, en = 1;
    logic          wg = 0, wb = 0, ordr = 0;
    logic [LN-1:0] ls = '0;
    logic [WW-1:0] wd = '0;
    logic [WW-1:0] rdata;
    logic          rvalid;

    int n_chk  = 0;
    int n_fail = 0;

    logic [WW-1:0] ref_mem [DEPTH];
    logic          m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;
    logic          m_ord = 0;

    logic          e1_v = 0, e2_v = 0, e1_c = 0, e2_c = 0;
    logic [WW-1:0] e1_d = '0, e2_d = '0;
    string         e1_t = "", e2_t = "";

    always #10 clk = ~clk;

    burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
        .clk (clk), .rst_n (rst_n), .addr_i (addr),
        .strobe_proc_i (sp), .strobe_ctl_i (sc), .adv_i (adv),
        .en_hi_a_i (ea), .en_hi_b_i (eb), .en_lo_n_i (en),
        .wr_global_i (wg), .wr_byte_i (wb), .lane_sel_i (ls),
        .wdata_i (wd), .order_i (ordr),
        .rdata_o (rdata), .rvalid_o (rvalid)
    );

    function automatic logic [WW-1:0] pat(input int a);
        logic [7:0] b;
        b = 8'(a);
        return {4'h5, b, b ^ 8'h3C, ~b, b + 8'd7};
    endfunction

    task automatic check(input string tag, input logic gv, input logic [WW-1:0] gd,
                         input logic xv, input logic [WW-1:0] xd);
        n_chk++;
        if (gv !== xv || gd !== xd) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     tag, gv, gd, xv, xd);
        end
    endtask

    // one bus cycle; output for it is checked two falling edges later (R1)
    task automatic op(input logic s_p, input logic s_c, input logic a_v,
                      input logic c_a, input logic c_b, input logic c_n,
                      input logic g, input logic b, input logic [LN-1:0] l,
                      input logic [AW-1:0] a, input logic [WW-1:0] d,
                      input logic o, input string tag);
        logic          xv;
        logic [WW-1:0] xd;
        logic [1:0]    off;
        logic [AW-1:0] ba;
        if ((s_p || s_c) && c_a && c_b && !c_n) begin
            m_act = 1; m_base = a; m_cnt = 0; m_ord = o;
        end else if (s_p || s_c) begin
            m_act = 0;
        end else if (m_act && a_v) begin
            m_cnt = m_cnt + 2'd1;
        end
        xv = 0; xd = '0;
        if (m_act) begin
            off = m_ord ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
            ba  = {m_base[AW-1:2], off};
            if (g) begin
                ref_mem[ba] = d;
            end else if (b) begin
                for (int i = 0; i < LN; i++)
                    if (l[i]) ref_mem[ba][i*LW +: LW] = d[i*LW +: LW];
            end
            if (!(g || (b && l != '0))) begin
                xv = 1; xd = ref_mem[ba];
            end
        end
        @(negedge clk);
        if (e2_c) check(e2_t, rvalid, rdata, e2_v, e2_d);
        e2_v = e1_v; e2_d = e1_d; e2_c = e1_c; e2_t = e1_t;
        e1_v = xv;   e1_d = xd;   e1_c = 1;    e1_t = tag;
        sp = s_p; sc = s_c; adv = a_v; ea = c_a; eb = c_b; en = c_n;
        wg = g; wb = b; ls = l; addr = a; wd = d; ordr = o;
    endtask

    task automatic rd_start(input logic [AW-1:0] a, input logic o, input string tag);
        op(1, 0, 0, 1, 1, 0, 0, 0, '0, a, '0, o, tag);
    endtask

    task automatic step(input logic a_v, input string tag);
        op(0, 0, a_v, 1, 1, 0, 0, 0, '0, '0, '0, 0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11", rvalid, rdata, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", rvalid, rdata, 1'b0, '0);

        // fill with global-write bursts, alternating strobes (R9, R2, R10)
        for (int blk = 0; blk < DEPTH / 4; blk++)
            for (int k = 0; k < 4; k++)
                op(k == 0 && blk[0], k == 0 && !blk[0], k != 0, 1, 1, 0, 1, 0, '0,
                   AW'(blk * 4), pat(blk * 4 + k), 0, "R9");

        // linear order from each offset, five beats to show the wrap (R5, R4)
        for (int o = 0; o < 4; o++) begin
            rd_start(AW'(40 + o), 0, "R5");
            for (int k = 1; k < 5; k++) step(1, "R5");
        end

        // interleaved order from each offset via the other strobe (R6)
        for (int o = 0; o < 4; o++) begin
            op(0, 1, 0, 1, 1, 0, 0, 0, '0, AW'(80 + o), '0, 1, "R6");
            for (int k = 1; k < 5; k++) step(1, "R6");
        end

        // repeat a beat when advance is low (R4)
        rd_start(AW'(61), 0, "R4");
        step(0, "R4");
        step(1, "R4");
        step(0, "R4");
        step(1, "R4");

        // single read latency (R1)
        rd_start(AW'(30), 0, "R1");

        // every lane mask with byte-write enabled, then ignored (R7, R8, R10)
        for (int m = 0; m < 16; m++) begin
            op(1, 0, 0, 1, 1, 0, 0, 1, LN'(m), AW'(120 + m), ~pat(m + 500), 0, "R7");
            rd_start(AW'(120 + m), 0, "R7");
            op(1, 0, 0, 1, 1, 0, 0, 0, LN'(m), AW'(140 + m), {WW{1'b1}}, 0, "R8");
            rd_start(AW'(140 + m), 0, "R8");
        end

        // global write overrides byte controls (R9)
        op(1, 0, 0, 1, 1, 0, 1, 1, '0, AW'(200), pat(900), 0, "R9");
        rd_start(AW'(200), 0, "R9");
        op(1, 0, 0, 1, 1, 0, 1, 0, 4'b0101, AW'(201), pat(901), 0, "R9");
        rd_start(AW'(201), 0, "R9");

        // write immediately followed by read of the same word (R12)
        for (int i = 0; i < 8; i++) begin
            op(0, 1, 0, 1, 1, 0, 0, 1, 4'hF, AW'(210 + i), pat(700 + i), 1, "R12");
            rd_start(AW'(210 + i), 0, "R12");
        end

        // each enable dropped in turn, then a good start (R3, R2)
        for (int e = 0; e < 3; e++) begin
            op(1, 0, 0, e != 0, e != 1, e == 2, 0, 0, '0, AW'(10), '0, 0, "R3");
            step(1, "R3");
            step(0, "R3");
            op(0, 1, 0, 1, 1, 0, 0, 0, '0, AW'(11 + e), '0, 0, "R2");
        end

        // drain the pipeline with deselects (R3)
        for (int k = 0; k < 3; k++) op(1, 0, 0, 0, 1, 0, 0, 0, '0, '0, '0, 0, "R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got no end of run, expected finish before timeout");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule